// File: doc/BRIEF.md
# Virtual interrupt maintenance status generator

This block produces the maintenance-interrupt status word of a virtual CPU interface. On every clock it examines the list-register occupancy and the hypervisor's per-condition enables. It also looks at the two virtual group enables, the end-of-interrupt counter field and the end-of-interrupt status vector. From these it registers an 8-bit set of condition flags. A hypervisor reads the flags to learn why a maintenance interrupt fired, for example that the list registers are running dry or that a guest has switched a group off.

The flags are presented zero-extended to a 64-bit read value. A single request line is the OR of all flags, qualified by a global virtual-interface enable. The number of list registers is a parameter from 1 to 16. Set packets generated by software do not reach this block, so they never affect the flags.

Top module: `vmaint_status_gen`

## Requirements
- R1: `status_o` is 64 bits wide and bits 63..8 are always 0. The flags sit at bit 7 group-1-disabled, 6 group-1-enabled, 5 group-0-disabled, 4 group-0-enabled, 3 no-pending, 2 entry-not-present, 1 underflow, 0 end-of-interrupt.
- R2: Bit 7 is set when `ie_i[6]`=1 and `vgrp1_en_i`=0. Bit 6 is set when `ie_i[5]`=1 and `vgrp1_en_i`=1.
- R3: Bit 5 is set when `ie_i[4]`=1 and `vgrp0_en_i`=0. Bit 4 is set when `ie_i[3]`=1 and `vgrp0_en_i`=1.
- R4: Each list register has a 2-bit state field: 00 invalid, 01 pending, 10 active, 11 pending-and-active. Bit 3 is set when `ie_i[2]`=1 and no entry has state 01 or 11.
- R5: Bit 2 is set when `ie_i[1]`=1 and `eoi_cnt_i` is non-zero.
- R6: Bit 1 is set when `ie_i[0]`=1 and at most one entry has a non-zero state.
- R7: Bit 0 is set when any bit of `eoi_status_i` is 1. It has no enable.
- R8: While `rst_ni` is low, all flags are 0.
- R9: `maint_irq_o` equals `vif_en_i` AND the OR of `status_o[7:0]`. When `vif_en_i`=0 it is 0.
- R10: Each flag reflects the inputs present at the preceding rising clock edge, with exactly one cycle of latency.
- R11: The disabled and enabled flags of the same group are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vif_en_i | input | 1 | Global virtual-interface enable for the request line |
| ie_i | input | 7 | Condition enables: [6] g1 disabled, [5] g1 enabled, [4] g0 disabled, [3] g0 enabled, [2] no pending, [1] entry not present, [0] underflow |
| eoi_cnt_i | input | EOI_CNT_W | End-of-interrupt count field |
| vgrp0_en_i | input | 1 | Virtual group 0 enable |
| vgrp1_en_i | input | 1 | Virtual group 1 enable |
| lr_state_i | input | 2*NUM_LR | Per-entry 2-bit state; entry n uses bits [2n+1:2n] |
| eoi_status_i | input | NUM_LR | End-of-interrupt status vector |
| status_o | output | 64 | Registered flag word, zero-extended |
| maint_irq_o | output | 1 | Maintenance interrupt request |

## Verification
The no-pending and underflow flags both depend on list-register occupancy, so they can rise in the same cycle. This happens when the last pending entry retires, or when the list holds one active-only entry. Directed cases build 0, 1, 2 and all-valid occupancies, including active-only entries, with both enables set. The whole flag word is then compared against a bench model, so each flag is judged on its own. Seeded random stimulus also turns on the end-of-interrupt flag alongside the group flags, and each case compares the full word and the request line.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;

    localparam int unsigned FLAG_W  = 8;
    localparam int unsigned READ_W  = 64;
    localparam int unsigned IE_W    = 7;
    localparam int unsigned STATE_W = 2;

    // Packed so that the first member lands on bit 7.
    typedef struct packed {
        logic g1_dis;
        logic g1_en;
        logic g0_dis;
        logic g0_en;
        logic no_pend;
        logic lr_enp;
        logic underflow;
        logic eoi;
    } vmaint_flags_t;

    typedef struct packed {
        logic g1_dis;
        logic g1_en;
        logic g0_dis;
        logic g0_en;
        logic no_pend;
        logic lr_enp;
        logic underflow;
    } vmaint_ie_t;

endpackage

// File: rtl/vmaint_lr_scan.sv
module vmaint_lr_scan #(
    parameter int unsigned NUM_LR = 4,
    localparam int unsigned CNT_W = $clog2(NUM_LR + 1)
) (
    input  logic [2*NUM_LR-1:0] lr_state_i,
    output logic                any_pending_o,
    output logic [CNT_W-1:0]    valid_cnt_o,
    output logic                at_most_one_o
);

    logic [NUM_LR-1:0] valid_vec;
    logic [NUM_LR-1:0] pend_vec;

    // Per-entry decode: any non-zero state is valid, state bit 0 marks pending.
    for (genvar n = 0; n < NUM_LR; n++) begin : g_entry
        assign valid_vec[n] = |lr_state_i[2*n +: 2];
        assign pend_vec[n]  = lr_state_i[2*n];
    end

    always_comb begin
        valid_cnt_o = '0;
        for (int n = 0; n < NUM_LR; n++) begin
            valid_cnt_o = valid_cnt_o + CNT_W'(valid_vec[n]);
        end
    end

    assign any_pending_o = |pend_vec;
    assign at_most_one_o = (valid_cnt_o <= CNT_W'(1));

endmodule

// File: rtl/vmaint_cond.sv
module vmaint_cond
    import vmaint_pkg::*;
#(
    parameter int unsigned NUM_LR    = 4,
    parameter int unsigned EOI_CNT_W = 5
) (
    input  vmaint_ie_t           ie_i,
    input  logic                 vgrp0_en_i,
    input  logic                 vgrp1_en_i,
    input  logic                 any_pending_i,
    input  logic                 at_most_one_i,
    input  logic [EOI_CNT_W-1:0] eoi_cnt_i,
    input  logic [NUM_LR-1:0]    eoi_status_i,
    output vmaint_flags_t        flags_o
);

    always_comb begin
        flags_o           = '0;
        flags_o.g1_dis    = ie_i.g1_dis & ~vgrp1_en_i;
        flags_o.g1_en     = ie_i.g1_en  &  vgrp1_en_i;
        flags_o.g0_dis    = ie_i.g0_dis & ~vgrp0_en_i;
        flags_o.g0_en     = ie_i.g0_en  &  vgrp0_en_i;
        flags_o.no_pend   = ie_i.no_pend & ~any_pending_i;
        flags_o.lr_enp    = ie_i.lr_enp & (|eoi_cnt_i);
        flags_o.underflow = ie_i.underflow & at_most_one_i;
        flags_o.eoi       = |eoi_status_i;
    end

endmodule

// File: rtl/vmaint_status_gen.sv
module vmaint_status_gen
    import vmaint_pkg::*;
#(
    parameter int unsigned NUM_LR    = 4,
    parameter int unsigned EOI_CNT_W = 5,
    localparam int unsigned CNT_W    = $clog2(NUM_LR + 1)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 vif_en_i,
    input  logic [IE_W-1:0]      ie_i,
    input  logic [EOI_CNT_W-1:0] eoi_cnt_i,
    input  logic                 vgrp0_en_i,
    input  logic                 vgrp1_en_i,
    input  logic [2*NUM_LR-1:0]  lr_state_i,
    input  logic [NUM_LR-1:0]    eoi_status_i,
    output logic [READ_W-1:0]    status_o,
    output logic                 maint_irq_o
);

    logic             any_pending;
    logic [CNT_W-1:0] valid_cnt;
    logic             at_most_one;
    vmaint_flags_t    cond_flags;
    vmaint_flags_t    status_d;
    vmaint_flags_t    status_q;

    vmaint_lr_scan #(.NUM_LR(NUM_LR)) u_scan (
        .lr_state_i    (lr_state_i),
        .any_pending_o (any_pending),
        .valid_cnt_o   (valid_cnt),
        .at_most_one_o (at_most_one)
    );

    vmaint_cond #(.NUM_LR(NUM_LR), .EOI_CNT_W(EOI_CNT_W)) u_cond (
        .ie_i          (vmaint_ie_t'(ie_i)),
        .vgrp0_en_i    (vgrp0_en_i),
        .vgrp1_en_i    (vgrp1_en_i),
        .any_pending_i (any_pending),
        .at_most_one_i (at_most_one),
        .eoi_cnt_i     (eoi_cnt_i),
        .eoi_status_i  (eoi_status_i),
        .flags_o       (cond_flags)
    );

    always_comb begin
        status_d = cond_flags;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o    = {{(READ_W-FLAG_W){1'b0}}, status_q};
    assign maint_irq_o = vif_en_i & (|status_q);

    // Independent occupancy view used only by the checks below.
    logic [NUM_LR-1:0] chk_valid;
    logic [NUM_LR-1:0] chk_pend;
    for (genvar n = 0; n < NUM_LR; n++) begin : g_chk
        assign chk_valid[n] = lr_state_i[2*n] | lr_state_i[2*n+1];
        assign chk_pend[n]  = lr_state_i[2*n];
    end

    assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[READ_W-1:FLAG_W] == '0);
    assert_g1_dis_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ie_i[6] && !vgrp1_en_i) |=> status_o[7]);
    assert_g1_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ie_i[5] && vgrp1_en_i) |=> status_o[6]);
    assert_g0_dis_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ie_i[4] && !vgrp0_en_i) |=> status_o[5]);
    assert_g0_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ie_i[3] && vgrp0_en_i) |=> status_o[4]);
    assert_no_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ie_i[2] && chk_pend == '0) |=> status_o[3]);
    assert_pend_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chk_pend != '0) |=> !status_o[3]);
    assert_lrenp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_cnt_i == '0) |=> !status_o[2]);
    assert_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ie_i[0] && $countones(chk_valid) <= 1) |=> status_o[1]);
    assert_occupied_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(chk_valid) > 1) |=> !status_o[1]);
    assert_eoi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_status_i != '0) |=> status_o[0]);
    assert_eoi_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eoi_status_i == '0) |=> !status_o[0]);
    assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vif_en_i |-> !maint_irq_o);
    assert_grp_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(status_o[7] && status_o[6]) && !(status_o[5] && status_o[4]));

endmodule

// File: tb/tb_vmaint_status_gen.sv
module tb_vmaint_status_gen;

    localparam int unsigned NUM_LR    = 4;
    localparam int unsigned EOI_CNT_W = 5;

    logic                 clk = 1'b0;
    logic                 rst_ni = 1'b0;
    logic                 vif_en_i = 1'b0;
    logic [6:0]           ie_i = '0;
    logic [EOI_CNT_W-1:0] eoi_cnt_i = '0;
    logic                 vgrp0_en_i = 1'b0;
    logic                 vgrp1_en_i = 1'b0;
    logic [2*NUM_LR-1:0]  lr_state_i = '0;
    logic [NUM_LR-1:0]    eoi_status_i = '0;
    logic [63:0]          status_o;
    logic                 maint_irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vmaint_status_gen #(.NUM_LR(NUM_LR), .EOI_CNT_W(EOI_CNT_W)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .vif_en_i(vif_en_i), .ie_i(ie_i),
        .eoi_cnt_i(eoi_cnt_i), .vgrp0_en_i(vgrp0_en_i), .vgrp1_en_i(vgrp1_en_i),
        .lr_state_i(lr_state_i), .eoi_status_i(eoi_status_i),
        .status_o(status_o), .maint_irq_o(maint_irq_o)
    );

    function automatic logic [7:0] model();
        logic [7:0] f = '0;
        int valid = 0;
        int pend  = 0;
        for (int n = 0; n < NUM_LR; n++) begin
            if (lr_state_i[2*n +: 2] != 2'b00) valid++;
            if (lr_state_i[2*n +: 2] == 2'b01 || lr_state_i[2*n +: 2] == 2'b11) pend++;
        end
        f[7] = ie_i[6] && !vgrp1_en_i;
        f[6] = ie_i[5] &&  vgrp1_en_i;
        f[5] = ie_i[4] && !vgrp0_en_i;
        f[4] = ie_i[3] &&  vgrp0_en_i;
        f[3] = ie_i[2] && (pend == 0);
        f[2] = ie_i[1] && (eoi_cnt_i != 0);
        f[1] = ie_i[0] && (valid <= 1);
        f[0] = (eoi_status_i != 0);
        return f;
    endfunction

    task automatic check64(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Inputs are set after a falling edge; the result is sampled 1 ns after the next rising edge.
    task automatic step_check(string req);
        logic [7:0] e;
        e = model();
        @(posedge clk);
        #1;
        check64(req, status_o, {56'b0, e});
        check64({req, " irq R9"}, {63'b0, maint_irq_o}, {63'b0, vif_en_i && (e != 0)});
        @(negedge clk);
    endtask

    task automatic set_occ(int cnt, logic [1:0] st);
        lr_state_i = '0;
        for (int n = 0; n < cnt; n++) lr_state_i[2*n +: 2] = st;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] prev;
        void'($urandom(32'd20240611));
        // R8: flags stay 0 during reset even with every condition live.
        ie_i = 7'h7F; eoi_status_i = '1; eoi_cnt_i = 5'd3; vif_en_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check64("R8 reset", status_o, 64'h0);
        check64("R8 reset irq", {63'b0, maint_irq_o}, 64'h0);
        @(negedge clk);
        rst_ni = 1'b1;
        ie_i = '0; eoi_status_i = '0; eoi_cnt_i = '0;
        step_check("R1 all off");

        // R6 and R4 occupancy sweep: 0, 1, 2, full, with pending and active-only entries.
        ie_i = 7'b0000101;
        for (int s = 1; s <= 3; s++) begin
            set_occ(0, 2'(s)); step_check("R6 R4 occ0");
            set_occ(1, 2'(s)); step_check("R6 R4 occ1");
            set_occ(2, 2'(s)); step_check("R6 R4 occ2");
            set_occ(NUM_LR, 2'(s)); step_check("R6 R4 full");
        end

        // R5 entry-not-present: zero and non-zero count, with and without enable.
        lr_state_i = '0; ie_i = 7'b0000010;
        eoi_cnt_i = '0;  step_check("R5 cnt zero");
        eoi_cnt_i = '1;  step_check("R5 cnt max");
        ie_i = '0;       step_check("R5 enable off");

        // R2 R3 R11: each group enable with both of its enables on.
        ie_i = 7'b1111000;
        for (int g = 0; g < 4; g++) begin
            vgrp0_en_i = g[0]; vgrp1_en_i = g[1];
            step_check("R2 R3 R11 groups");
        end

        // R7: single bits of the status vector, no enable needed.
        ie_i = '0;
        for (int b = 0; b < NUM_LR; b++) begin
            eoi_status_i = NUM_LR'(1) << b;
            step_check("R7 eoi bit");
        end
        eoi_status_i = '0; step_check("R7 eoi clear");

        // R9: request line masked by the global enable.
        eoi_status_i = 4'b0010; vif_en_i = 1'b0; step_check("R9 masked");
        vif_en_i = 1'b1; #1;
        check64("R9 enable same cycle", {63'b0, maint_irq_o}, 64'h1);

        // R10: flags hold the old value until the next rising edge.
        prev = status_o;
        eoi_status_i = '0; ie_i = '0;
        #1;
        check64("R10 latency", status_o, prev);
        step_check("R10 after edge");

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            vif_en_i     = 1'($urandom);
            ie_i         = 7'($urandom);
            eoi_cnt_i    = ($urandom % 3 == 0) ? '0 : EOI_CNT_W'($urandom);
            vgrp0_en_i   = 1'($urandom);
            vgrp1_en_i   = 1'($urandom);
            lr_state_i   = 8'($urandom);
            eoi_status_i = ($urandom % 2 == 0) ? '0 : NUM_LR'($urandom);
            step_check("R1-random R2 R3 R4 R5 R6 R7");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule